// File: doc/BRIEF.md
# Receive Mailbox Bank Allocator

This block holds a bank of receive mailboxes for a CAN-style controller. A decoded frame (identifier, extended flag, remote-request flag, length code and eight data bytes) arrives on a one-cycle strobe. The frame is written into the lowest-numbered mailbox that is enabled for reception and currently empty. A stored mailbox stays full until software re-arms it by writing a bitmask. If no mailbox is free, the lowest full mailbox in overwrite mode takes the new frame and raises a lost-message flag. If there is no such mailbox either, the frame is dropped.

Software uses a small register port. A global word shows one ready bit per mailbox. A re-arm register takes a bitmask. Each mailbox has a window of words: mode, identifier, status, data low and data high. The mailbox window starts at byte 0x200 with a stride of 0x20. Inside a window the offsets are: mode 0x00, identifier 0x08, status 0x10, data low 0x14, data high 0x18. The global ready word is at 0x000 and the re-arm register at 0x004. Reads are combinational. A read of a status word takes effect at the clock edge it spans.

Each mailbox runs a two-state machine. The states are `MB_EMPTY` and `MB_FULL`. The transitions are:
- **fill**: `MB_EMPTY` to `MB_FULL` when the allocator stores a frame.
- **overwrite**: `MB_FULL` to `MB_FULL` when a frame is stored again; this sets the lost flag.
- **rearm**: `MB_FULL` to `MB_EMPTY` when the mailbox's re-arm bit is written.
- **idle**: the mailbox stays in its state when none of the above applies.

Top module: `rx_mbx_bank`

## Requirements
- R1: After reset every mailbox is empty, the global ready word reads 0, and every mode word reads 0, which means disabled.
- R2: A frame is stored in the lowest-numbered mailbox whose mode is 1 (receive) or 2 (receive with overwrite) and that is empty. That mailbox's ready bit is set after the clock edge on which the strobe is sampled.
- R3: Mailboxes in mode 0, 3, 4 or 5 never take a frame. A frame arrives and no mailbox can take it in either of two cases: every enabled mailbox is full and none is in overwrite mode, or no mailbox is enabled. In both cases the frame is dropped, and the ready word and the stored contents stay unchanged.
- R4: A write to the re-arm register clears the ready bit of every mailbox whose bit (bit i for mailbox i) is 1. Other mailboxes are unaffected, and bits at or above the mailbox count are ignored.
- R5: Bit i of the global ready word is the ready state of mailbox i. Bits above the last mailbox read 0.
- R6: The identifier word depends on the extended flag. For a standard frame it holds the 11-bit identifier at bits 28:18 with bit 29 at 0. For an extended frame it holds the 29-bit identifier at bits 28:0 with bit 29 at 1.
- R7: The status word holds the length at bits 19:16, the remote-request flag at bit 20, ready at bit 23 and lost at bit 24. The data low word is bytes 0-3 of the payload (payload bits 31:0), and the data high word is payload bits 63:32.
- R8: Suppose no mailbox is free and a mailbox in mode 2 is full. The lowest such mailbox is then overwritten with the new frame, and its lost flag (status bit 24) is set.
- R9: A read of a mailbox status word returns the current lost flag and then clears it.
- R10: The mode word reads back the mode at bits 26:24 and the 4-bit priority at bits 19:16, with all other bits 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frm_valid | input | 1 | One-cycle strobe for an incoming frame |
| frm_id | input | 29 | Identifier; only the low 11 bits are used for standard frames |
| frm_ext | input | 1 | Extended-identifier flag |
| frm_rtr | input | 1 | Remote-request flag |
| frm_len | input | 4 | Length code |
| frm_data | input | 64 | Payload, with byte 0 in bits 7:0 |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 10 | Byte address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational from the address |

## Verification
The assertions assume three things about the inputs. First, a frame strobe never falls on the same edge as a re-arm or a status read that targets the mailbox the allocator would pick. Second, mode writes never coincide with a frame. Third, read and write strobes are never both high in one cycle. The stimulus meets these assumptions by giving each action its own clock cycle: frames, register writes and register reads are applied in separate cycles and are never overlapped.

// File: rtl/rx_mbx_pkg.sv
package rx_mbx_pkg;

    typedef struct packed {
        logic [28:0] id;
        logic        ext;
        logic        rtr;
        logic [3:0]  len;
        logic [63:0] data;
    } rx_frame_t;

    typedef enum logic [2:0] {
        MODE_OFF    = 3'd0,
        MODE_RX     = 3'd1,
        MODE_RX_OVR = 3'd2,
        MODE_TX     = 3'd3,
        MODE_CONS   = 3'd4,
        MODE_PROD   = 3'd5
    } mb_mode_e;

    typedef enum logic {
        MB_EMPTY = 1'b0,
        MB_FULL  = 1'b1
    } mb_state_e;

endpackage

// File: rtl/rx_mbx_alloc.sv
module rx_mbx_alloc #(
    parameter int NUM = 12
) (
    input  logic           frm_valid,
    input  logic [NUM-1:0] rx_en,
    input  logic [NUM-1:0] ovr_en,
    input  logic [NUM-1:0] full,
    output logic [NUM-1:0] store
);
    logic [NUM-1:0] free_vec;
    logic [NUM-1:0] ovr_vec;
    logic [NUM-1:0] pick_free;
    logic [NUM-1:0] pick_ovr;

    assign free_vec = rx_en & ~full;
    assign ovr_vec  = ovr_en & full;

    // lowest set bit of each candidate vector
    always_comb begin
        pick_free = '0;
        pick_ovr  = '0;
        for (int i = NUM - 1; i >= 0; i--) begin
            if (free_vec[i]) pick_free = NUM'(1) << i;
            if (ovr_vec[i])  pick_ovr  = NUM'(1) << i;
        end
    end

    always_comb begin
        store = '0;
        if (frm_valid) begin
            if (|free_vec) store = pick_free;
            else           store = pick_ovr;
        end
    end
endmodule

// File: rtl/rx_mbx_slot.sv
module rx_mbx_slot
    import rx_mbx_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       mode_we,
    input  logic [2:0] mode_in,
    input  logic [3:0] prio_in,
    input  logic       store,
    input  rx_frame_t  frm_in,
    input  logic       rearm,
    input  logic       stat_rd,
    output logic [2:0] mode_q,
    output logic [3:0] prio_q,
    output logic       full,
    output logic       lost,
    output rx_frame_t  frm_q
);
    mb_state_e st, st_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= MB_EMPTY;
        else        st <= st_nx;
    end

    always_comb begin
        st_nx = st;
        unique case (st)
            MB_EMPTY: if (store) st_nx = MB_FULL;
            MB_FULL: begin
                if (store)      st_nx = MB_FULL;
                else if (rearm) st_nx = MB_EMPTY;
            end
            default: st_nx = MB_EMPTY;
        endcase
    end

    always_comb full = (st == MB_FULL);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lost   <= 1'b0;
            frm_q  <= '0;
            mode_q <= MODE_OFF;
            prio_q <= '0;
        end else begin
            if (store) frm_q <= frm_in;
            if (store && st == MB_FULL) lost <= 1'b1;
            else if (stat_rd)           lost <= 1'b0;
            if (mode_we) begin
                mode_q <= mode_in;
                prio_q <= prio_in;
            end
        end
    end

    p_fill_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (st == MB_EMPTY && store) |=> full);
    p_rearm_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (st == MB_FULL && rearm && !store) |=> !full);
    p_lost_src_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lost) |-> $past(st == MB_FULL));
    p_lost_clr_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd && !store) |=> !lost);
endmodule

// File: rtl/rx_mbx_bank.sv
module rx_mbx_bank
    import rx_mbx_pkg::*;
#(
    parameter int NUM    = 12,
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frm_valid,
    input  logic [28:0]       frm_id,
    input  logic              frm_ext,
    input  logic              frm_rtr,
    input  logic [3:0]        frm_len,
    input  logic [63:0]       frm_data,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata
);
    localparam logic [ADDR_W-1:0] A_READY = ADDR_W'(12'h000);
    localparam logic [ADDR_W-1:0] A_REARM = ADDR_W'(12'h004);
    localparam logic [2:0] OFF_MODE = 3'd0;
    localparam logic [2:0] OFF_ID   = 3'd2;
    localparam logic [2:0] OFF_STAT = 3'd4;
    localparam logic [2:0] OFF_DLO  = 3'd5;
    localparam logic [2:0] OFF_DHI  = 3'd6;

    rx_frame_t      frm_in;
    logic [NUM-1:0] rx_en, ovr_en, full, lost, store, rearm;
    logic [NUM-1:0] mode_we, stat_rd;
    logic [2:0]     mode_q [NUM];
    logic [3:0]     prio_q [NUM];
    rx_frame_t      frm_q  [NUM];

    logic           in_mbx;
    logic [3:0]     mb_idx;
    logic [2:0]     mb_off;

    assign frm_in = '{id: frm_id, ext: frm_ext, rtr: frm_rtr,
                      len: frm_len, data: frm_data};
    assign in_mbx = reg_addr[9];
    assign mb_idx = reg_addr[8:5];
    assign mb_off = reg_addr[4:2];
    assign rearm  = (reg_wr && reg_addr == A_REARM) ? reg_wdata[NUM-1:0] : '0;

    logic unused_bits;
    assign unused_bits = ^{reg_addr[1:0], reg_wdata};

    rx_mbx_alloc #(.NUM(NUM)) i_alloc (
        .frm_valid (frm_valid),
        .rx_en     (rx_en),
        .ovr_en    (ovr_en),
        .full      (full),
        .store     (store)
    );

    for (genvar g = 0; g < NUM; g++) begin : g_slot
        assign mode_we[g] = reg_wr && in_mbx && int'(mb_idx) == g && mb_off == OFF_MODE;
        assign stat_rd[g] = reg_rd && in_mbx && int'(mb_idx) == g && mb_off == OFF_STAT;
        assign rx_en[g]   = (mode_q[g] == MODE_RX) || (mode_q[g] == MODE_RX_OVR);
        assign ovr_en[g]  = (mode_q[g] == MODE_RX_OVR);

        rx_mbx_slot i_slot (
            .clk     (clk),
            .rst_n   (rst_n),
            .mode_we (mode_we[g]),
            .mode_in (reg_wdata[26:24]),
            .prio_in (reg_wdata[19:16]),
            .store   (store[g]),
            .frm_in  (frm_in),
            .rearm   (rearm[g]),
            .stat_rd (stat_rd[g]),
            .mode_q  (mode_q[g]),
            .prio_q  (prio_q[g]),
            .full    (full[g]),
            .lost    (lost[g]),
            .frm_q   (frm_q[g])
        );
    end

    always_comb begin
        reg_rdata = '0;
        if (!in_mbx) begin
            if (reg_addr == A_READY) reg_rdata = {{(32-NUM){1'b0}}, full};
        end else if (int'(mb_idx) < NUM) begin
            unique case (mb_off)
                OFF_MODE: reg_rdata = {5'b0, mode_q[mb_idx], 4'b0, prio_q[mb_idx], 16'b0};
                OFF_ID:   reg_rdata = frm_q[mb_idx].ext
                                    ? {2'b0, 1'b1, frm_q[mb_idx].id}
                                    : {3'b0, frm_q[mb_idx].id[10:0], 18'b0};
                OFF_STAT: reg_rdata = {7'b0, lost[mb_idx], full[mb_idx], 2'b0,
                                       frm_q[mb_idx].rtr, frm_q[mb_idx].len, 16'b0};
                OFF_DLO:  reg_rdata = frm_q[mb_idx].data[31:0];
                OFF_DHI:  reg_rdata = frm_q[mb_idx].data[63:32];
                default:  reg_rdata = '0;
            endcase
        end
    end

    p_one_target_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(store));
    p_no_take_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_valid && !(|(rx_en & ~full)) && !(|(ovr_en & full)) && rearm == '0)
        |=> full == $past(full));
endmodule

// File: tb/test_rx_mbx_bank.sv
`timescale 1ns/1ps
module test_rx_mbx_bank;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        frm_valid = 1'b0;
    logic [28:0] frm_id = '0;
    logic        frm_ext = 1'b0;
    logic        frm_rtr = 1'b0;
    logic [3:0]  frm_len = '0;
    logic [63:0] frm_data = '0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [9:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    rx_mbx_bank i_rx_mbx_bank (
        .clk, .rst_n, .frm_valid, .frm_id, .frm_ext, .frm_rtr, .frm_len,
        .frm_data, .reg_wr, .reg_rd, .reg_addr, .reg_wdata, .reg_rdata
    );

    // {ext, rtr, len, id, data}
    localparam logic [98:0] TBL [6] = '{
        {1'b0, 1'b0, 4'd8,  29'h0000123,  64'h0011223344556677},
        {1'b1, 1'b0, 4'd4,  29'h1ABCDEF0, 64'hDEADBEEF00000001},
        {1'b0, 1'b1, 4'd0,  29'h00007FF,  64'h0000000000000000},
        {1'b1, 1'b1, 4'd15, 29'h0000001,  64'hFFFFFFFFFFFFFFFF},
        {1'b0, 1'b0, 4'd3,  29'h1F00400,  64'hA5A5A5A55A5A5A5A},
        {1'b1, 1'b0, 4'd8,  29'h1FFFFFFF, 64'h0123456789ABCDEF}
    };

    function automatic logic [9:0] mba(int i, int off);
        return 10'(32'h200 + i * 32 + off);
    endfunction

    function automatic logic [31:0] exp_id(logic ext, logic [28:0] id);
        return ext ? {3'b001, id} : {3'b000, id[10:0], 18'b0};
    endfunction

    function automatic logic [31:0] exp_stat(logic lst, logic rtr, logic [3:0] len);
        return {7'b0, lst, 1'b1, 2'b0, rtr, len, 16'b0};
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(logic [9:0] a, logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(logic [9:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic send(logic ext, logic rtr, logic [3:0] len, logic [28:0] id, logic [63:0] dat);
        @(negedge clk);
        frm_valid = 1'b1; frm_ext = ext; frm_rtr = rtr; frm_len = len;
        frm_id = id; frm_data = dat;
        @(negedge clk);
        frm_valid = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(10'h000, v); chk("R1 ready word", v, 32'h0);
        rd(mba(0, 0), v); chk("R1 mode word", v, 32'h0);
        // R3 all disabled: frame dropped
        send(1'b0, 1'b0, 4'd1, 29'h55, 64'h1);
        rd(10'h000, v); chk("R3 disabled drop", v, 32'h0);

        // R10 mode setup
        for (int i = 0; i < 11; i++) wr(mba(i, 0), 32'h0100_0000);
        wr(mba(11, 0), 32'h0205_0000);
        rd(mba(11, 0), v); chk("R10 mode readback", v, 32'h0205_0000);
        rd(mba(3, 0), v);  chk("R10 mode rx", v, 32'h0100_0000);

        // table walk: R2 R5 R6 R7
        for (int k = 0; k < 6; k++) begin
            logic [98:0] e;
            e = TBL[k];
            send(e[98], e[97], e[96:93], e[92:64], e[63:0]);
            rd(10'h000, v); chk("R5 ready word", v, (32'h1 << (k + 1)) - 1);
            rd(mba(k, 8), v);  chk("R6 id word", v, exp_id(e[98], e[92:64]));
            rd(mba(k, 16), v); chk("R7 status word", v, exp_stat(1'b0, e[97], e[96:93]));
            rd(mba(k, 20), v); chk("R7 data low", v, e[31:0]);
            rd(mba(k, 24), v); chk("R7 data high", v, e[63:32]);
        end

        // R4 selective re-arm, high bits ignored
        wr(10'h004, 32'hFFFF_F005);
        rd(10'h000, v); chk("R4 rearm mask", v, 32'h0000_003A);
        // R2 lowest free
        send(1'b0, 1'b0, 4'd2, 29'h0AA, 64'h22);
        rd(10'h000, v); chk("R2 lowest free", v, 32'h0000_003B);
        rd(mba(0, 8), v); chk("R2 id in mb0", v, exp_id(1'b0, 29'h0AA));
        // R3 mailbox 2 in transmit mode skipped
        wr(mba(2, 0), 32'h0300_0000);
        send(1'b1, 1'b0, 4'd5, 29'h33333, 64'h33);
        rd(10'h000, v); chk("R3 tx mode skipped", v, 32'h0000_007B);
        rd(mba(6, 8), v); chk("R3 frame in mb6", v, exp_id(1'b1, 29'h33333));

        // fill everything, then overwrite the last mailbox
        wr(10'h004, 32'h0000_0FFF);
        rd(10'h000, v); chk("R4 rearm all", v, 32'h0);
        wr(mba(2, 0), 32'h0100_0000);
        for (int i = 0; i < 12; i++) send(1'b0, 1'b0, 4'd1, 29'(i + 16), 64'(i));
        rd(10'h000, v); chk("R5 all full", v, 32'h0000_0FFF);
        rd(mba(11, 16), v); chk("R9 no lost yet", v, exp_stat(1'b0, 1'b0, 4'd1));
        send(1'b1, 1'b1, 4'd7, 29'h0ABCDE, 64'h7777);
        rd(mba(11, 8), v); chk("R8 overwritten id", v, exp_id(1'b1, 29'h0ABCDE));
        rd(mba(11, 16), v); chk("R8 lost set", v, exp_stat(1'b1, 1'b1, 4'd7));
        rd(mba(11, 16), v); chk("R9 lost cleared", v, exp_stat(1'b0, 1'b1, 4'd7));
        rd(mba(10, 8), v); chk("R8 mb10 untouched", v, exp_id(1'b0, 29'd26));

        // R3 no overwrite mailbox: frame dropped
        wr(mba(11, 0), 32'h0100_0000);
        send(1'b0, 1'b0, 4'd2, 29'h111, 64'h99);
        rd(10'h000, v); chk("R3 drop ready", v, 32'h0000_0FFF);
        rd(mba(11, 8), v); chk("R3 drop contents", v, exp_id(1'b1, 29'h0ABCDE));
        rd(mba(0, 8), v);  chk("R3 drop mb0", v, exp_id(1'b0, 29'd16));

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule